// File: doc/BRIEF.md
# Serial Transmit Holding and Shift Control

This block is the transmit half of a classic byte-oriented serial port. A host writes bytes into either a single holding register or, with buffered mode on, a 16-slot transmit queue. The block moves each byte into a shift register as its own timed step and then counts out one serial frame per byte. Time is measured only in baud ticks: single-cycle strobes on `baud_tick` from an external rate generator. The block keeps two status bits. One says the holding side is empty (`thre`). The other says the whole transmitter has drained (`temt`). It also drives a transmit interrupt request.

A move from holding storage to the shift register waits a fixed 8 ticks if the shifter is idle. If the shifter is already busy, the move instead waits as many ticks as the configured number of data bits. A byte counts as sent once a full frame length of ticks has passed. On that event the byte is handed to a line serializer, which then drives `txd` low for the start bit, sends the data bits least significant first, then the optional parity bit, then high stop bits. Each bit lasts one tick. The line therefore runs exactly one frame behind the completion event.

Top module: `uart_tx_engine`

## Requirements
- R1: After synchronous reset, `thre` and `temt` are 1, `tx_irq` is 0 and `txd` is 1.
- R2: In unbuffered mode (`fifo_mode`=0), a write clears `thre` and `temt`. On the 8th baud tick after the write the byte moves into the shift register, and `thre` and `tx_irq` go to 1.
- R3: In unbuffered mode, the byte completes on the frame-length-th tick after its move. At that point `temt` becomes 1 and `tx_irq` returns to 0.
- R4: Frame length in ticks is 2 + data bits + `par_en` + `stop2`, where data bits is 5, 6, 7 or 8 for `data_len` codes 0, 1, 2, 3.
- R5: `txd` idles at 1. Starting at the completion edge of a byte, it carries one bit per tick: a 0 start bit, the data bits LSB first, and then, if `par_en`=1, a parity bit equal to the XOR of the data bits, inverted when `par_odd`=1. High stop bits follow.
- R6: In buffered mode (`fifo_mode`=1), the first 15 writes of a burst start nothing: ticks leave `thre`=0, `tx_irq`=0 and `txd`=1. The 16th write starts the transmitter.
- R7: In buffered mode, the k-th byte of a burst completes on tick 8 + k·F after the 16th write, where F is the frame length. Each later byte moves in after data-bits ticks while the shifter keeps counting.
- R8: In buffered mode, `thre` and `tx_irq` rise only when the 16th byte moves in, on tick 8 + 15·F + data bits.
- R9: In buffered mode, `temt` rises and `tx_irq` falls when the 16th byte completes. Both queue pointers wrap to slot 0, so an identical following burst repeats the same timing and data.
- R10: Without a baud tick, the transmitter makes no progress: `thre` stays 0 however many clock cycles pass after a write.
- R11: `temt` is never 1 while `thre` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for holding storage |
| wr_data | input | 8 | Byte to store |
| fifo_mode | input | 1 | 1 selects the 16-slot queue, 0 the single holding register |
| data_len | input | 2 | Data bit count code (0..3 gives 5..8 bits) |
| par_en | input | 1 | Adds a parity bit to the frame |
| par_odd | input | 1 | Inverts the parity bit |
| stop2 | input | 1 | Adds a second stop bit |
| baud_tick | input | 1 | One-cycle baud strobe |
| txd | output | 1 | Serial line, idle high |
| thre | output | 1 | Holding side empty |
| temt | output | 1 | Holding side and shifter both empty |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit data, a 16-slot queue and an 8-tick move delay. With that small setup it can sweep all 32 combinations of data length, parity enable, parity sense and stop count in unbuffered mode, and check every tick of each frame against timing and bit values computed arithmetically. A 16-slot queue is short enough to run complete bursts. Two back-to-back bursts in one format reach the pointer wrap, and the bench also runs a second format that uses the shortest data length.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef struct packed {
      logic [1:0] len_code;
      logic       par_en;
      logic       par_odd;
      logic       stop2;
   } tx_fmt_t;

   // data bit count for a length code: widest minus three, plus code
   function automatic int unsigned data_bits_of(int unsigned data_w, logic [1:0] code);
      return data_w - 3 + {30'd0, code};
   endfunction

   // start + data + optional parity + one or two stops
   function automatic int unsigned frame_bits_of(int unsigned dbits, logic pe, logic s2);
      return dbits + 2 + {31'd0, pe} + {31'd0, s2};
   endfunction

endpackage

// File: rtl/uart_tx_store.sv
module uart_tx_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int PTR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              fifo_mode,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              start,
   output logic              rd_wrap
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0]  wptr_q, rptr_q;
   logic              wr_last, rd_last;

   assign wr_last = (wptr_q == LAST);
   assign rd_last = (rptr_q == LAST);
   assign start   = wr_en & (~fifo_mode | wr_last);
   assign rd_wrap = pop & fifo_mode & rd_last;
   assign head    = fifo_mode ? slot_q[rptr_q] : hold_q;

   // single holding register, emptied when its byte moves on
   always_ff @(posedge clk) begin
      if (rst)                    hold_q <= '0;
      else if (!fifo_mode && wr_en) hold_q <= wr_data;
      else if (!fifo_mode && pop)   hold_q <= '0;
   end

   // queue slots, each written at the write pointer and emptied at the read pointer
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst)
            slot_q[g] <= '0;
         else if (fifo_mode && wr_en && wptr_q == PTR_W'(g))
            slot_q[g] <= wr_data;
         else if (fifo_mode && pop && rptr_q == PTR_W'(g))
            slot_q[g] <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr_q <= '0;
         rptr_q <= '0;
      end else begin
         if (fifo_mode && wr_en) wptr_q <= wr_last ? '0 : wptr_q + PTR_W'(1);
         if (fifo_mode && pop)   rptr_q <= rd_last ? '0 : rptr_q + PTR_W'(1);
      end
   end

   p_rd_wrap_to_zero_r9: assert property (@(posedge clk) disable iff (rst)
      rd_wrap |=> (rptr_q == '0));

   p_start_empties_wptr_r6: assert property (@(posedge clk) disable iff (rst)
      (start && fifo_mode) |=> (wptr_q == '0));

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq #(
   parameter int DATA_W     = 8,
   parameter int DEPTH      = 16,
   parameter int MOVE_DELAY = 8,
   parameter int CNT_MAX    = 12,
   parameter int CNT_W      = $clog2(CNT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              start,
   input  logic              fifo_mode,
   input  logic [CNT_W-1:0]  dbits,
   input  logic [CNT_W-1:0]  flen,
   input  logic [DATA_W-1:0] head,
   input  logic              rd_wrap,
   output logic              pop,
   output logic              done,
   output logic [DATA_W-1:0] done_byte,
   output logic              thre,
   output logic              temt,
   output logic              irq
);

   localparam int SENT_W = $clog2(DEPTH + 1);

   logic              mv_q, sh_q;
   logic [CNT_W-1:0]  cnt_q, cnt_n, dly;
   logic [SENT_W-1:0] sent_q;
   logic [DATA_W-1:0] tsr_q;
   logic              thre_q, temt_q, irq_q;
   logic              active;

   assign active    = mv_q | sh_q;
   assign cnt_n     = cnt_q + CNT_W'(1);
   assign dly       = (mv_q && sh_q) ? dbits : CNT_W'(MOVE_DELAY);
   assign done      = tick & sh_q & (cnt_n == flen);
   assign pop       = tick & mv_q & ~done & (cnt_n == dly);
   assign done_byte = tsr_q;
   assign thre      = thre_q;
   assign temt      = temt_q;
   assign irq       = irq_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         mv_q   <= 1'b0;
         sh_q   <= 1'b0;
         cnt_q  <= '0;
         sent_q <= '0;
         tsr_q  <= '0;
         thre_q <= 1'b1;
         temt_q <= 1'b1;
         irq_q  <= 1'b0;
      end else begin
         if (tick && active) begin
            if (done) begin
               cnt_q <= '0;
               tsr_q <= '0;
               irq_q <= 1'b0;
               if (fifo_mode && sent_q < SENT_W'(DEPTH)) begin
                  mv_q <= 1'b1;
               end else begin
                  sh_q   <= 1'b0;
                  sent_q <= '0;
                  if (thre_q) temt_q <= 1'b1;
               end
            end else if (pop) begin
               tsr_q  <= head;
               mv_q   <= 1'b0;
               sh_q   <= 1'b1;
               sent_q <= sent_q + SENT_W'(1);
               cnt_q  <= sh_q ? cnt_n : '0;
               if (!fifo_mode || rd_wrap) begin
                  thre_q <= 1'b1;
                  irq_q  <= 1'b1;
               end
            end else begin
               cnt_q <= cnt_n;
            end
         end else if (tick) begin
            cnt_q  <= '0;
            sent_q <= '0;
         end
         if (wr_en) begin
            thre_q <= 1'b0;
            temt_q <= 1'b0;
         end
         if (start) begin
            mv_q   <= 1'b1;
            sent_q <= '0;
         end
      end
   end

   p_temt_needs_thre_r11: assert property (@(posedge clk) disable iff (rst)
      temt_q |-> thre_q);

   p_irq_drops_on_done_r3: assert property (@(posedge clk) disable iff (rst)
      (done && !wr_en) |=> !irq_q);

   p_thre_on_move_r2: assert property (@(posedge clk) disable iff (rst)
      (pop && !fifo_mode && !wr_en) |=> thre_q);

   p_sent_bound_r7: assert property (@(posedge clk) disable iff (rst)
      sent_q <= SENT_W'(DEPTH));

   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_W'(CNT_MAX));

   p_no_tick_no_move_r10: assert property (@(posedge clk) disable iff (rst)
      (!tick && !start) |=> ($stable(cnt_q) && $stable(sh_q) && $stable(mv_q)));

endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] byte_in,
   input  logic [CNT_W-1:0]  dbits,
   input  logic [CNT_W-1:0]  flen,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              txd
);

   localparam int FW    = DATA_W + 4;
   localparam int IDX_W = $clog2(FW);

   logic [FW-1:0]     frame, shreg_q;
   logic [DATA_W-1:0] mask;
   logic [IDX_W-1:0]  pidx;
   logic [CNT_W-1:0]  left_q;
   logic              par;

   always_comb begin
      mask = '0;
      for (int i = 0; i < DATA_W; i++)
         if (CNT_W'(i) < dbits) mask[i] = 1'b1;
      par   = (^(byte_in & mask)) ^ par_odd;
      pidx  = IDX_W'(dbits) + IDX_W'(1);
      frame = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++)
         if (mask[i]) frame[i+1] = byte_in[i];
      if (par_en) frame[pidx] = par;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg_q <= '1;
         left_q  <= '0;
      end else if (load) begin
         shreg_q <= frame;
         left_q  <= flen;
      end else if (tick && left_q != '0) begin
         shreg_q <= {1'b1, shreg_q[FW-1:1]};
         left_q  <= left_q - CNT_W'(1);
      end
   end

   assign txd = (left_q != '0) ? shreg_q[0] : 1'b1;

   p_load_sends_start_r5: assert property (@(posedge clk) disable iff (rst)
      load |=> !txd);

   p_left_bound_r4: assert property (@(posedge clk) disable iff (rst)
      left_q <= CNT_W'(FW));

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
   import uart_tx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 16,
   parameter int MOVE_DELAY = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              fifo_mode,
   input  logic [1:0]        data_len,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              stop2,
   input  logic              baud_tick,
   output logic              txd,
   output logic              thre,
   output logic              temt,
   output logic              tx_irq
);

   localparam int MAX_FRAME = DATA_W + 4;
   localparam int CNT_MAX   = (MAX_FRAME > MOVE_DELAY) ? MAX_FRAME : MOVE_DELAY;
   localparam int CNT_W     = $clog2(CNT_MAX + 1);
   localparam int PTR_W     = $clog2(FIFO_DEPTH);

   if (DATA_W < 5)      begin : g_bad_width $error("DATA_W must be at least 5"); end
   if (FIFO_DEPTH < 2)  begin : g_bad_depth $error("FIFO_DEPTH must be at least 2"); end
   if (MOVE_DELAY < 1)  begin : g_bad_delay $error("MOVE_DELAY must be at least 1"); end

   tx_fmt_t           fmt;
   logic [CNT_W-1:0]  dbits, flen;
   logic [DATA_W-1:0] head, done_byte;
   logic              start, rd_wrap, pop, done;

   assign fmt   = '{len_code: data_len, par_en: par_en, par_odd: par_odd, stop2: stop2};
   assign dbits = CNT_W'(data_bits_of(DATA_W, fmt.len_code));
   assign flen  = CNT_W'(frame_bits_of(data_bits_of(DATA_W, fmt.len_code), fmt.par_en, fmt.stop2));

   uart_tx_store #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .PTR_W(PTR_W)) u_store (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .fifo_mode(fifo_mode),
      .pop(pop), .head(head), .start(start), .rd_wrap(rd_wrap));

   uart_tx_seq #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .MOVE_DELAY(MOVE_DELAY),
                 .CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst(rst), .tick(baud_tick), .wr_en(wr_en), .start(start),
      .fifo_mode(fifo_mode), .dbits(dbits), .flen(flen), .head(head), .rd_wrap(rd_wrap),
      .pop(pop), .done(done), .done_byte(done_byte), .thre(thre), .temt(temt), .irq(tx_irq));

   uart_tx_line #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_line (
      .clk(clk), .rst(rst), .tick(baud_tick), .load(done), .byte_in(done_byte),
      .dbits(dbits), .flen(flen), .par_en(fmt.par_en), .par_odd(fmt.par_odd), .txd(txd));

endmodule

// File: tb/sim_uart_tx_engine.sv
`timescale 1ns/1ps
module sim_uart_tx_engine;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       fifo_mode = 1'b0;
   logic [1:0] data_len = '0;
   logic       par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
   logic       baud_tick = 1'b0;
   logic       txd, thre, temt, tx_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   uart_tx_engine u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .fifo_mode(fifo_mode),
      .data_len(data_len), .par_en(par_en), .par_odd(par_odd), .stop2(stop2),
      .baud_tick(baud_tick), .txd(txd), .thre(thre), .temt(temt), .tx_irq(tx_irq));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick1();
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
      @(negedge clk) wr_en = 1'b0;
   endtask

   function automatic logic [11:0] mk_frame(input logic [7:0] d, input int db,
                                            input int pe, input int po);
      logic [11:0] f = '1;
      logic p = 1'b0;
      f[0] = 1'b0;
      for (int i = 0; i < db; i++) begin
         f[1+i] = d[i];
         p ^= d[i];
      end
      if (pe != 0) f[1+db] = p ^ po[0];
      return f;
   endfunction

   // one byte in unbuffered mode, every tick checked
   task automatic run_single(input int code, input int pe, input int po, input int s2,
                             input logic [7:0] d);
      int db = 5 + code;
      int fl = 2 + db + pe + s2;
      logic [11:0] fr = mk_frame(d, db, pe, po);
      data_len = code[1:0]; par_en = pe[0]; par_odd = po[0]; stop2 = s2[0];
      fifo_mode = 1'b0;
      wr(d);
      chk("R2 thre after write", int'(thre), 0);
      chk("R2 temt after write", int'(temt), 0);
      repeat (6) @(negedge clk);
      chk("R10 thre without ticks", int'(thre), 0);
      for (int t = 1; t <= 8 + 2*fl + 1; t++) begin
         tick1();
         chk("R2 thre timing", int'(thre), (t >= 8) ? 1 : 0);
         chk("R3 irq window", int'(tx_irq), (t >= 8 && t < 8 + fl) ? 1 : 0);
         chk("R3 R4 temt timing", int'(temt), (t >= 8 + fl) ? 1 : 0);
         chk("R5 txd bit", int'(txd),
             (t >= 8 + fl && t < 8 + 2*fl) ? int'(fr[t-8-fl]) : 1);
      end
   endtask

   // one 16-byte burst in buffered mode
   task automatic run_burst(input int code, input int pe, input int po, input int s2,
                            input int seed);
      int db = 5 + code;
      int fl = 2 + db + pe + s2;
      logic [11:0] fr [16];
      logic [7:0]  b;
      data_len = code[1:0]; par_en = pe[0]; par_odd = po[0]; stop2 = s2[0];
      fifo_mode = 1'b1;
      for (int k = 0; k < 16; k++) begin
         b = 8'(seed + k * 37);
         fr[k] = mk_frame(b, db, pe, po);
         wr(b);
         if (k == 14) begin
            for (int t = 0; t < 20; t++) begin
               tick1();
               chk("R6 no start thre", int'(thre), 0);
               chk("R6 no start irq", int'(tx_irq), 0);
               chk("R6 no start txd", int'(txd), 1);
            end
         end
      end
      for (int t = 1; t <= 8 + 17*fl + 1; t++) begin
         int k, j, e;
         tick1();
         chk("R8 thre timing", int'(thre), (t >= 8 + 15*fl + db) ? 1 : 0);
         chk("R8 irq window", int'(tx_irq), (t >= 8 + 15*fl + db && t < 8 + 16*fl) ? 1 : 0);
         chk("R9 temt timing", int'(temt), (t >= 8 + 16*fl) ? 1 : 0);
         e = 1;
         if (t >= 8 + fl && t < 8 + 17*fl) begin
            k = (t - 8) / fl;
            j = t - 8 - k * fl;
            e = int'(fr[k-1][j]);
         end
         chk("R7 R5 txd burst bit", int'(txd), e);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 thre reset", int'(thre), 1);
      chk("R1 temt reset", int'(temt), 1);
      chk("R1 irq reset", int'(tx_irq), 0);
      chk("R1 txd reset", int'(txd), 1);
      for (int c = 0; c < 32; c++)
         run_single(c & 3, (c >> 2) & 1, (c >> 3) & 1, (c >> 4) & 1, 8'(8'hA5 ^ (c * 29)));
      run_burst(3, 1, 0, 1, 11);
      run_burst(3, 1, 0, 1, 11);
      run_burst(0, 0, 1, 0, 200);
      run_single(1, 1, 1, 0, 8'h3C);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule